// File: doc/BRIEF.md
# Three-Channel Doorbell Interrupt Unit

This block lets one processor ring a doorbell on another through a small register-mapped slave port in the APB style. It holds three physical channels: a low-priority channel and a high-priority channel for non-secure traffic, and one secure channel. Each channel keeps a 32-bit status word. Every bit of the word is a separate doorbell, or subchannel. The sender raises bits by writing ones to a set register. The receiver clears the bits it has serviced by writing ones to a clear register. Either side can read the current word through a status register.

Each channel drives its own level interrupt, which is the registered OR of all 32 status bits. The interrupt stays high until the receiver has cleared every pending bit of that channel. A non-secure requester cannot reach the secure channel: it reads zero, its writes are dropped, and the transfer ends with an error response.

Top module: `dbell_mbox`

## Requirements
- R1: Reset (synchronous, active high) clears every status bit, and every interrupt output is low in the cycle after reset is sampled.
- R2: Channel c (0 = low-priority non-secure, 1 = high-priority non-secure, 2 = secure) sits at byte address 0x20*c. Within a channel, offset 0x00 is the status register, 0x08 the set register and 0x10 the clear register. Any other address returns zero and ignores writes: address bits above bit 6 nonzero, channel field 3, or an unused offset. Such an address gives no error. Reads of the set and clear registers return zero.
- R3: A write to a set register ORs the write data into that channel's status word. Zero bits leave the matching status bits unchanged, and a write of all zeros has no effect.
- R4: A write to a clear register clears each status bit whose write-data bit is one and leaves every other bit unchanged.
- R5: A read of a status register returns the current status word during the access phase. Writes to a status register are ignored.
- R6: Interrupt c is the OR of channel c's status bits, taken from a register. It changes at the second rising edge after the access phase of the write that changed the status: one edge updates the status, the next updates the interrupt.
- R7: An interrupt stays high while any bit of its channel is set, including after a clear that leaves other bits pending.
- R8: An access with pprot[1]=1 (non-secure) to channel 2 reads zero, changes no status bit, and completes with pslverr=1. Secure accesses to channel 2, and accesses of either kind to channels 0 and 1, complete without error.
- R9: pready is always 1, so every transfer has zero wait states. pslverr is 1 only during an access phase.
- R10: A write to one channel leaves the status words of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pprot | input | 3 | Protection; bit 1 set means non-secure |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Error response for a blocked secure-channel access |
| irq_o | output | 3 | Per-channel level interrupts, index = channel |

## Verification
Read data and the error response come from combinational logic, so they are due in the access phase itself. The bench samples them one nanosecond after the falling edge that raises penable, before the closing rising edge. A status change is due at that closing edge and becomes visible on the next read. The matching interrupt is due one edge later. The bench therefore checks each interrupt twice: once at the falling edge just after the write, where it must still hold its old value, and once a cycle later, where it must show the new one.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int NCH      = 3;
    localparam int DW       = 32;
    localparam int AW       = 12;
    localparam int SEC_CH   = 2;
    localparam int CH_LSB   = 5;
    localparam int CHW      = $clog2(NCH + 1);
    localparam int REG_LSB  = 3;
    localparam int REGW     = 2;
    localparam int MAP_TOP  = CH_LSB + CHW;

    typedef enum logic [REGW-1:0] {
        REG_STAT = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_NONE = 2'd3
    } reg_e;

    typedef struct packed {
        logic            hit;
        logic            wr;
        logic [CHW-1:0]  ch;
        reg_e            kind;
        logic            denied;
    } acc_t;

    function automatic logic [DW-1:0] stat_next(
        input logic [DW-1:0] cur,
        input logic [DW-1:0] set_bits,
        input logic [DW-1:0] clr_bits
    );
        return (cur & ~clr_bits) | set_bits;
    endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
(
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic          nonsec,
    output acc_t          acc
);
    logic           in_map;
    logic [CHW-1:0] ch_f;
    logic [REGW-1:0] rg_f;

    always_comb begin
        ch_f   = paddr[CH_LSB +: CHW];
        rg_f   = paddr[REG_LSB +: REGW];
        in_map = (paddr[AW-1:MAP_TOP] == '0) && (int'(ch_f) < NCH);

        acc.hit    = psel && penable && in_map;
        acc.wr     = pwrite;
        acc.ch     = ch_f;
        acc.kind   = reg_e'(rg_f);
        acc.denied = acc.hit && (int'(ch_f) == SEC_CH) && nonsec;
    end
endmodule

// File: rtl/dbell_chan.sv
module dbell_chan
    import dbell_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat,
    output logic          irq
);
    logic [DW-1:0] set_bits;
    logic [DW-1:0] clr_bits;

    always_comb begin
        set_bits = set_en ? wdata : '0;
        clr_bits = clr_en ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            irq  <= 1'b0;
        end else begin
            stat <= stat_next(stat, set_bits, clr_bits);
            irq  <= |stat;
        end
    end
endmodule

// File: rtl/dbell_rdmux.sv
module dbell_rdmux
    import dbell_pkg::*;
(
    input  acc_t                   acc,
    input  logic [NCH-1:0][DW-1:0] stat,
    output logic [DW-1:0]          rdata,
    output logic                   err
);
    always_comb begin
        rdata = '0;
        if (acc.hit && !acc.wr && !acc.denied && acc.kind == REG_STAT) begin
            for (int c = 0; c < NCH; c++) begin
                if (int'(acc.ch) == c) rdata = stat[c];
            end
        end
        err = acc.denied;
    end
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
    import dbell_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [2:0]    pprot,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    output logic [NCH-1:0] irq_o
);
    acc_t                   acc;
    logic [NCH-1:0][DW-1:0] stat_w;
    logic                   wr_ok;

    dbell_decode u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .nonsec  (pprot[1]),
        .acc     (acc)
    );

    assign wr_ok  = acc.hit && acc.wr && !acc.denied;
    assign pready = 1'b1;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel_c;
        assign sel_c = wr_ok && (int'(acc.ch) == c);
        dbell_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .set_en (sel_c && acc.kind == REG_SET),
            .clr_en (sel_c && acc.kind == REG_CLR),
            .wdata  (pwdata),
            .stat   (stat_w[c]),
            .irq    (irq_o[c])
        );
    end

    dbell_rdmux u_rd (
        .acc   (acc),
        .stat  (stat_w),
        .rdata (prdata),
        .err   (pslverr)
    );
endmodule

// File: rtl/dbell_sva.sv
module dbell_sva
    import dbell_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           psel,
    input logic           penable,
    input logic           pwrite,
    input logic [AW-1:0]  paddr,
    input logic [2:0]     pprot,
    input logic [DW-1:0]  pwdata,
    input logic [DW-1:0]  prdata,
    input logic           pready,
    input logic           pslverr,
    input logic [NCH-1:0] irq_o
);
    logic       a_acc;
    logic       a_map;
    logic [1:0] a_ch;
    logic [1:0] a_rg;
    logic       a_ns;

    assign a_acc = psel && penable;
    assign a_map = (paddr[AW-1:7] == '0);
    assign a_ch  = paddr[6:5];
    assign a_rg  = paddr[4:3];
    assign a_ns  = pprot[1];

    AST_RESET_IRQ_LOW: assert property (@(posedge clk)
        rst |=> (irq_o == '0)); // R1

    AST_PREADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        pready); // R9

    AST_ERR_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> a_acc); // R9

    AST_NS_SEC_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (a_acc && a_map && a_ch == 2'd2 && a_ns) |-> (pslverr && prdata == '0)); // R8

    AST_NS_SEC_NO_IRQ_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (a_acc && pwrite && a_map && a_ch == 2'd2 && a_ns) |=> ##1 $stable(irq_o[2])); // R8

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic allowed;
        assign allowed = a_acc && pwrite && a_map && a_ch == 2'(c)
                         && !(c == SEC_CH && a_ns);

        AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
            (allowed && a_rg == 2'd1 && pwdata != '0) |=> ##1 irq_o[c]); // R6

        AST_CLR_ALL_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
            (allowed && a_rg == 2'd2 && pwdata == '1) |=> ##1 !irq_o[c]); // R7
    end
endmodule

bind dbell_mbox dbell_sva u_sva (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pprot   (pprot),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .irq_o   (irq_o)
);

// File: tb/dbell_mbox_tb.sv
`timescale 1ns/1ps
module dbell_mbox_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [2:0]  pprot;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [2:0]  irq_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dbell_mbox dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pprot(pprot), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        ns;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 12'h008, 32'h5,        32'h0,        1'b0, 4'd3},  // R3
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h5,        1'b0, 4'd5},  // R5
        '{1'b0, 1'b1, 12'h008, 32'h0,        32'h0,        1'b0, 4'd3},  // R3 zero write
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h5,        1'b0, 4'd3},
        '{1'b0, 1'b1, 12'h010, 32'h1,        32'h0,        1'b0, 4'd4},  // R4
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h4,        1'b0, 4'd4},
        '{1'b0, 1'b1, 12'h028, 32'h80000000, 32'h0,        1'b0, 4'd10}, // R10
        '{1'b0, 1'b0, 12'h020, 32'h0,        32'h80000000, 1'b0, 4'd10},
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h4,        1'b0, 4'd10},
        '{1'b0, 1'b1, 12'h000, 32'hFFFF,     32'h0,        1'b0, 4'd5},  // R5 write to status
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h4,        1'b0, 4'd5},
        '{1'b1, 1'b1, 12'h048, 32'hFF,       32'h0,        1'b1, 4'd8},  // R8
        '{1'b1, 1'b0, 12'h040, 32'h0,        32'h0,        1'b1, 4'd8},
        '{1'b0, 1'b0, 12'h040, 32'h0,        32'h0,        1'b0, 4'd8},
        '{1'b0, 1'b1, 12'h048, 32'h30,       32'h0,        1'b0, 4'd8},
        '{1'b0, 1'b0, 12'h040, 32'h0,        32'h30,       1'b0, 4'd8},
        '{1'b1, 1'b0, 12'h040, 32'h0,        32'h0,        1'b1, 4'd8},
        '{1'b1, 1'b1, 12'h050, 32'h30,       32'h0,        1'b1, 4'd8},
        '{1'b0, 1'b0, 12'h040, 32'h0,        32'h30,       1'b0, 4'd8},
        '{1'b0, 1'b0, 12'h008, 32'h0,        32'h0,        1'b0, 4'd2},  // R2
        '{1'b0, 1'b1, 12'h068, 32'hF,        32'h0,        1'b0, 4'd2},
        '{1'b0, 1'b0, 12'h060, 32'h0,        32'h0,        1'b0, 4'd2},
        '{1'b1, 1'b0, 12'h000, 32'h0,        32'h4,        1'b0, 4'd8},
        '{1'b0, 1'b1, 12'h018, 32'hF,        32'h0,        1'b0, 4'd2},
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h4,        1'b0, 4'd2},
        '{1'b0, 1'b1, 12'h808, 32'h1,        32'h0,        1'b0, 4'd2},
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h4,        1'b0, 4'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb(input logic ns, input logic wr, input logic [11:0] a,
                       input logic [31:0] d, output logic [31:0] rd, output logic err);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        pprot = {1'b0, ns, 1'b0};
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd  = prdata;
        err = pslverr;
        check("R9 pready", {31'd0, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        err;
        psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pprot = '0;
        do_reset();
        @(negedge clk);
        check("R1 irq after reset", {29'd0, irq_o}, 32'd0);
        check("R9 idle pslverr", {31'd0, pslverr}, 32'd0);
        for (int c = 0; c < 3; c++) begin
            apb(1'b0, 1'b0, 12'(c * 32), 32'h0, rd, err);
            check("R1 status after reset", rd, 32'h0);
        end

        for (int i = 0; i < NV; i++) begin
            apb(VEC[i].ns, VEC[i].wr, VEC[i].addr, VEC[i].wd, rd, err);
            check($sformatf("R%0d err vec %0d", VEC[i].req, i), {31'd0, err}, {31'd0, VEC[i].exp_err});
            if (!VEC[i].wr)
                check($sformatf("R%0d rdata vec %0d", VEC[i].req, i), rd, VEC[i].exp_rd);
        end

        // State now: ch0 = 0x4, ch1 = 0x80000000, ch2 = 0x30
        @(negedge clk);
        check("R6 all irqs high", {29'd0, irq_o}, 32'd7);

        apb(1'b0, 1'b1, 12'h010, 32'hFFFFFFFF, rd, err);
        check("R6 irq0 holds one cycle", {31'd0, irq_o[0]}, 32'd1);
        @(negedge clk);
        check("R6 irq0 drops", {31'd0, irq_o[0]}, 32'd0);

        apb(1'b0, 1'b1, 12'h008, 32'h208, rd, err);
        check("R6 irq0 not yet", {31'd0, irq_o[0]}, 32'd0);
        @(negedge clk);
        check("R6 irq0 rises", {31'd0, irq_o[0]}, 32'd1);

        apb(1'b0, 1'b1, 12'h010, 32'h8, rd, err);
        @(negedge clk);
        check("R7 irq0 held by bit 9", {31'd0, irq_o[0]}, 32'd1);
        apb(1'b0, 1'b0, 12'h000, 32'h0, rd, err);
        check("R4 remaining bit", rd, 32'h200);
        apb(1'b0, 1'b1, 12'h010, 32'h200, rd, err);
        @(negedge clk);
        check("R7 irq0 clears with last bit", {31'd0, irq_o[0]}, 32'd0);

        apb(1'b1, 1'b1, 12'h050, 32'hFFFFFFFF, rd, err);
        @(negedge clk);
        check("R8 irq2 unaffected by ns clear", {31'd0, irq_o[2]}, 32'd1);
        check("R10 irq1 unaffected", {31'd0, irq_o[1]}, 32'd1);

        do_reset();
        @(negedge clk);
        check("R1 irq after mid-run reset", {29'd0, irq_o}, 32'd0);
        for (int c = 0; c < 3; c++) begin
            apb(1'b0, 1'b0, 12'(c * 32), 32'h0, rd, err);
            check("R1 status after mid-run reset", rd, 32'h0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule